// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Bank

This block holds instructions that wait in front of one functional-unit group, for example the floating-point adders. An issue stage hands it an operation code and two source operands. Each operand arrives either as a finished value or as the nonzero tag of the station that will produce it later. The bank writes the instruction into a free slot and then snoops a shared result bus. When a broadcast carries the tag that a slot is waiting on, the slot stores the value. Renaming therefore happens inside the slots, and the register file is never read back.

A slot becomes eligible once neither of its operands has a pending producer. The bank then offers one eligible slot per cycle to the execution unit and chooses the slot with the lowest index. A dispatched slot stays occupied until the execution unit's own result appears on the bus with that slot's tag. Each slot's tag is fixed by its position, from a configurable nonzero base. One parameter sets the number of slots: three for an adder group and two for a multiplier group.

Top module: `rs_bank`

## Requirements
- R1: After reset every slot is free: `iss_ready` is 1, `iss_tag` equals `TAG_BASE` (1 by default) and `exe_valid` is 0.
- R2: An issue is taken when `iss_valid` and `iss_ready` are both 1. It fills the lowest-index free slot, and `iss_tag` shows that slot's tag, which is `TAG_BASE` plus the slot index. When every slot is occupied, `iss_ready` is 0 and an issue attempt changes nothing.
- R3: A source tag of 0 means the accompanying value is final. That operand is stored as given, and no broadcast alters it afterwards.
- R4: A slot is never offered for execution while either operand still has a nonzero producer tag.
- R5: A broadcast with `bus_valid`=1 whose `bus_tag` equals a waiting operand's producer tag stores `bus_val` into that operand and clears its tag. The slot becomes eligible in the following cycle. A broadcast with a different tag captures nothing.
- R6: A broadcast that arrives in the same cycle as an issue, and matches one of the issued operand tags, is stored directly into the new slot's operand.
- R7: Among eligible slots, the one with the lowest index is presented on `exe_*`. A slot is handed over in a cycle with `exe_valid`=1 and `exe_ready`=1, and at most one slot is handed over per cycle.
- R8: A dispatched slot becomes free in the cycle after the bus carries its own tag, and it can be allocated again from then on.
- R9: A slot that has been handed over is not offered a second time.
- R10: While `bus_valid` is 0, the bus has no effect on any slot, whatever tag it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code of the issued instruction |
| iss_a_tag | input | TAG_W | Producer tag of source A (0 means value present) |
| iss_a_val | input | DATA_W | Value of source A |
| iss_b_tag | input | TAG_W | Producer tag of source B (0 means value present) |
| iss_b_val | input | DATA_W | Value of source B |
| iss_ready | output | 1 | A slot is free; low means the issue stage must stall |
| iss_tag | output | TAG_W | Tag of the slot the next issue will fill |
| bus_valid | input | 1 | Result bus carries a broadcast |
| bus_tag | input | TAG_W | Tag of the broadcasting station |
| bus_val | input | DATA_W | Broadcast result value |
| exe_valid | output | 1 | An eligible slot is offered |
| exe_ready | input | 1 | Execution unit accepts the offered slot |
| exe_op | output | OP_W | Operation code of the offered slot |
| exe_a | output | DATA_W | Source A value of the offered slot |
| exe_b | output | DATA_W | Source B value of the offered slot |
| exe_tag | output | TAG_W | Tag of the offered slot |

## Verification
The assertions check every cycle that an issue is refused only when all slots are occupied, that the advertised issue tag belongs to a free slot, and that the offered slot has both operands present. They also check that a handshake moves the slot into execution and that a broadcast of a slot's own tag frees it. Only the bench scenarios can show which values are captured: same-cycle forwarding, the way zero tags ignore the bus, non-matching and invalid broadcasts, and the lowest-index ordering when slots become eligible out of order. The bench sweeps every combination of waiting operands together with early and late arrival of the result.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2
    } rs_state_e;

endpackage

// File: rtl/rs_pick.sv
// Lowest-index one-hot picker.
module rs_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);

    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
        any = |req;
    end

endmodule

// File: rtl/rs_entry.sv
// One station slot: two-process state, snoops the result bus.
module rs_entry
    import rs_pkg::*;
#(
    parameter int               TAG_W  = 4,
    parameter int               DATA_W = 32,
    parameter int               OP_W   = 3,
    parameter logic [TAG_W-1:0] MY_TAG = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [OP_W-1:0]   in_op,
    input  logic [TAG_W-1:0]  in_a_tag,
    input  logic [DATA_W-1:0] in_a_val,
    input  logic [TAG_W-1:0]  in_b_tag,
    input  logic [DATA_W-1:0] in_b_val,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_val,
    input  logic              grant,
    output logic              busy,
    output logic              ready,
    output logic              executing,
    output logic [OP_W-1:0]   out_op,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b
);

    typedef struct packed {
        rs_state_e         st;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  qa;
        logic [TAG_W-1:0]  qb;
        logic [DATA_W-1:0] va;
        logic [DATA_W-1:0] vb;
    } slot_t;

    slot_t slot_q, slot_d;
    logic  snoop;

    always_comb begin
        slot_d = slot_q;
        snoop  = bus_valid && (bus_tag != '0);
        case (slot_q.st)
            ST_FREE: begin
                if (alloc) begin
                    slot_d.st = ST_WAIT;
                    slot_d.op = in_op;
                    if ((in_a_tag != '0) && snoop && (bus_tag == in_a_tag)) begin
                        slot_d.va = bus_val;
                        slot_d.qa = '0;
                    end else begin
                        slot_d.va = in_a_val;
                        slot_d.qa = in_a_tag;
                    end
                    if ((in_b_tag != '0) && snoop && (bus_tag == in_b_tag)) begin
                        slot_d.vb = bus_val;
                        slot_d.qb = '0;
                    end else begin
                        slot_d.vb = in_b_val;
                        slot_d.qb = in_b_tag;
                    end
                end
            end
            ST_WAIT: begin
                if ((slot_q.qa != '0) && snoop && (bus_tag == slot_q.qa)) begin
                    slot_d.va = bus_val;
                    slot_d.qa = '0;
                end
                if ((slot_q.qb != '0) && snoop && (bus_tag == slot_q.qb)) begin
                    slot_d.vb = bus_val;
                    slot_d.qb = '0;
                end
                if (grant) begin
                    slot_d.st = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (snoop && (bus_tag == MY_TAG)) begin
                    slot_d.st = ST_FREE;
                end
            end
            default: slot_d.st = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign busy      = (slot_q.st != ST_FREE);
    assign ready     = (slot_q.st == ST_WAIT) && (slot_q.qa == '0) && (slot_q.qb == '0);
    assign executing = (slot_q.st == ST_EXEC);
    assign out_op    = slot_q.op;
    assign out_a     = slot_q.va;
    assign out_b     = slot_q.vb;

endmodule

// File: rtl/rs_bank.sv
module rs_bank #(
    parameter int N_ENTRY  = 3,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 32,
    parameter int OP_W     = 3,
    parameter int TAG_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_val,
    output logic              exe_valid,
    input  logic              exe_ready,
    output logic [OP_W-1:0]   exe_op,
    output logic [DATA_W-1:0] exe_a,
    output logic [DATA_W-1:0] exe_b,
    output logic [TAG_W-1:0]  exe_tag
);

    logic [N_ENTRY-1:0] busy, rdy, execu;
    logic [N_ENTRY-1:0] free_gnt, disp_gnt, alloc, grant;
    logic               free_any, disp_any;
    logic [OP_W-1:0]    e_op [N_ENTRY];
    logic [DATA_W-1:0]  e_a  [N_ENTRY];
    logic [DATA_W-1:0]  e_b  [N_ENTRY];

    rs_pick #(.N(N_ENTRY)) u_free_pick (
        .req (~busy),
        .gnt (free_gnt),
        .any (free_any)
    );

    rs_pick #(.N(N_ENTRY)) u_disp_pick (
        .req (rdy),
        .gnt (disp_gnt),
        .any (disp_any)
    );

    assign alloc = free_gnt & {N_ENTRY{iss_valid & free_any}};
    assign grant = disp_gnt & {N_ENTRY{exe_ready}};

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_slot
        rs_entry #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W),
            .OP_W   (OP_W),
            .MY_TAG (TAG_W'(TAG_BASE + g))
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc[g]),
            .in_op     (iss_op),
            .in_a_tag  (iss_a_tag),
            .in_a_val  (iss_a_val),
            .in_b_tag  (iss_b_tag),
            .in_b_val  (iss_b_val),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_val   (bus_val),
            .grant     (grant[g]),
            .busy      (busy[g]),
            .ready     (rdy[g]),
            .executing (execu[g]),
            .out_op    (e_op[g]),
            .out_a     (e_a[g]),
            .out_b     (e_b[g])
        );
    end

    always_comb begin
        iss_tag = '0;
        exe_op  = '0;
        exe_a   = '0;
        exe_b   = '0;
        exe_tag = '0;
        for (int i = 0; i < N_ENTRY; i++) begin
            if (free_gnt[i]) begin
                iss_tag = iss_tag | TAG_W'(TAG_BASE + i);
            end
            if (disp_gnt[i]) begin
                exe_op  = exe_op | e_op[i];
                exe_a   = exe_a | e_a[i];
                exe_b   = exe_b | e_b[i];
                exe_tag = exe_tag | TAG_W'(TAG_BASE + i);
            end
        end
    end

    assign iss_ready = free_any;
    assign exe_valid = disp_any;

endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk #(
    parameter int N_ENTRY  = 3,
    parameter int TAG_W    = 4,
    parameter int TAG_BASE = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               iss_ready,
    input logic [TAG_W-1:0]   iss_tag,
    input logic               exe_valid,
    input logic               exe_ready,
    input logic [TAG_W-1:0]   exe_tag,
    input logic               bus_valid,
    input logic [TAG_W-1:0]   bus_tag,
    input logic [N_ENTRY-1:0] busy,
    input logic [N_ENTRY-1:0] rdy,
    input logic [N_ENTRY-1:0] execu
);

    p_stall_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_ready |-> (&busy));

    p_offer_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid |-> ((32'(exe_tag) >= TAG_BASE) && (32'(exe_tag) < TAG_BASE + N_ENTRY)));

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_chk
        p_iss_tag_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_ready && (32'(iss_tag) == TAG_BASE + g)) |-> !busy[g]);

        p_offer_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (exe_valid && (32'(exe_tag) == TAG_BASE + g)) |-> rdy[g]);

        p_handover_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (exe_valid && exe_ready && (32'(exe_tag) == TAG_BASE + g)) |=> (execu[g] && !rdy[g]));

        p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (execu[g] && bus_valid && (32'(bus_tag) == TAG_BASE + g)) |=> !busy[g]);
    end

endmodule

bind rs_bank rs_bank_chk #(
    .N_ENTRY  (N_ENTRY),
    .TAG_W    (TAG_W),
    .TAG_BASE (TAG_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_ready (iss_ready),
    .iss_tag   (iss_tag),
    .exe_valid (exe_valid),
    .exe_ready (exe_ready),
    .exe_tag   (exe_tag),
    .bus_valid (bus_valid),
    .bus_tag   (bus_tag),
    .busy      (busy),
    .rdy       (rdy),
    .execu     (execu)
);

// File: tb/sim_rs_bank.sv
`timescale 1ns/1ps
module sim_rs_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [2:0]  iss_op = '0;
    logic [3:0]  iss_a_tag = '0, iss_b_tag = '0;
    logic [31:0] iss_a_val = '0, iss_b_val = '0;
    logic        iss_ready;
    logic [3:0]  iss_tag;
    logic        bus_valid = 1'b0;
    logic [3:0]  bus_tag = '0;
    logic [31:0] bus_val = '0;
    logic        exe_valid;
    logic        exe_ready = 1'b0;
    logic [2:0]  exe_op;
    logic [31:0] exe_a, exe_b;
    logic [3:0]  exe_tag;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rs_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
        .exe_valid(exe_valid), .exe_ready(exe_ready),
        .exe_op(exe_op), .exe_a(exe_a), .exe_b(exe_b), .exe_tag(exe_tag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] op, input logic [3:0] ta, input logic [31:0] va,
                         input logic [3:0] tb, input logic [31:0] vb);
        iss_valid = 1'b1; iss_op = op;
        iss_a_tag = ta; iss_a_val = va; iss_b_tag = tb; iss_b_val = vb;
        step();
        iss_valid = 1'b0;
    endtask

    task automatic bcast(input logic [3:0] t, input logic [31:0] v);
        bus_valid = 1'b1; bus_tag = t; bus_val = v;
        step();
        bus_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 iss_ready", 32'(iss_ready), 1);
        chk("R1 iss_tag", 32'(iss_tag), 1);
        chk("R1 exe_valid", 32'(exe_valid), 0);

        // Fill all three slots with ready operands
        for (int k = 0; k < 3; k++) begin
            chk("R2 iss_tag lowest free", 32'(iss_tag), 32'(k + 1));
            issue(3'(k), 4'd0, 32'(10 + k), 4'd0, 32'(20 + k));
        end
        chk("R2 full stall", 32'(iss_ready), 0);
        issue(3'd7, 4'd0, 32'd999, 4'd0, 32'd999);  // refused
        exe_ready = 1'b1;
        for (int k = 0; k < 3; k++) begin
            chk("R7 exe_valid", 32'(exe_valid), 1);
            chk("R7 order tag", 32'(exe_tag), 32'(k + 1));
            chk("R3 exe_a", exe_a, 32'(10 + k));
            chk("R3 exe_b", exe_b, 32'(20 + k));
            chk("R7 exe_op", 32'(exe_op), 32'(k));
            step();
        end
        exe_ready = 1'b0;
        chk("R9 no reoffer", 32'(exe_valid), 0);
        chk("R8 still busy", 32'(iss_ready), 0);
        bcast(4'd2, 32'd0);
        chk("R8 freed ready", 32'(iss_ready), 1);
        chk("R8 freed tag", 32'(iss_tag), 2);
        bcast(4'd1, 32'd0);
        chk("R8 freed tag1", 32'(iss_tag), 1);
        bcast(4'd3, 32'd0);
        chk("R2 refused issue absent", 32'(exe_valid), 0);
        chk("R8 all free", 32'(iss_ready), 1);

        // Waiting operand, invalid and mismatched broadcasts
        exe_ready = 1'b1;
        issue(3'd2, 4'd5, 32'd1, 4'd0, 32'd7);
        chk("R4 waiting not offered", 32'(exe_valid), 0);
        bus_valid = 1'b0; bus_tag = 4'd5; bus_val = 32'd99;
        step();
        chk("R10 invalid bus ignored", 32'(exe_valid), 0);
        bcast(4'd6, 32'd55);
        chk("R5 mismatch ignored", 32'(exe_valid), 0);
        bcast(4'd5, 32'd123);
        chk("R5 captured valid", 32'(exe_valid), 1);
        chk("R5 captured value", exe_a, 123);
        chk("R3 kept value", exe_b, 7);
        step();
        exe_ready = 1'b0;
        chk("R9 handed over", 32'(exe_valid), 0);
        bcast(4'd1, 32'd0);

        // Priority with out-of-order readiness
        issue(3'd1, 4'd8, 32'd0, 4'd0, 32'd11);
        issue(3'd2, 4'd0, 32'd42, 4'd0, 32'd43);
        issue(3'd3, 4'd0, 32'd12, 4'd9, 32'd0);
        chk("R7 only ready slot", 32'(exe_tag), 2);
        bcast(4'd9, 32'd77);
        chk("R7 lower index kept", 32'(exe_tag), 2);
        bcast(4'd8, 32'd66);
        chk("R7 lowest wins", 32'(exe_tag), 1);
        chk("R5 value slot1", exe_a, 66);
        exe_ready = 1'b1;
        step();
        chk("R7 next slot2", 32'(exe_tag), 2);
        step();
        chk("R7 next slot3", 32'(exe_tag), 3);
        chk("R5 value slot3", exe_b, 77);
        step();
        exe_ready = 1'b0;
        chk("R9 drained", 32'(exe_valid), 0);
        bcast(4'd1, 32'd0);
        bcast(4'd2, 32'd0);
        bcast(4'd3, 32'd0);

        // Sweep: which operands wait x early/late arrival of A's producer
        for (int w = 0; w < 4; w++) begin
            for (int f = 0; f < 2; f++) begin
                logic        wa, wb, pa;
                logic [31:0] abus, bbus;
                wa   = w[0];
                wb   = w[1];
                abus = 32'(300 + w * 2 + f);
                bbus = 32'(400 + w);
                pa   = wa && (f == 0);
                if (f == 1) begin
                    bus_valid = 1'b1; bus_tag = 4'd8; bus_val = abus;
                end
                issue(3'(w), wa ? 4'd8 : 4'd0, 32'(100 + w), wb ? 4'd9 : 4'd0, 32'(200 + w));
                bus_valid = 1'b0;
                chk("R4 ready only when complete", 32'(exe_valid), 32'(!(pa || wb)));
                if (pa) bcast(4'd8, abus);
                if (wb) bcast(4'd9, bbus);
                chk("R5 eventually ready", 32'(exe_valid), 1);
                chk(f ? "R6 forward A" : "R3 R5 operand A", exe_a, wa ? abus : 32'(100 + w));
                chk("R3 R5 operand B", exe_b, wb ? bbus : 32'(200 + w));
                exe_ready = 1'b1;
                step();
                exe_ready = 1'b0;
                bcast(4'd1, 32'd0);
                chk("R8 reusable", 32'(iss_tag), 1);
            end
        end

        finish_run();
    end

endmodule